// File: doc/BRIEF.md
# Floating-Point Sign-Inject, Compare and Min/Max Unit

This block handles the floating-point operations on two operands that need no rounding and no arithmetic on the magnitude. These are the sign-inject family, min/max selection and the quiet ordered compares. The operand width is chosen at build time by the `FLEN` parameter: 32 gives single precision and 64 gives double precision. The exponent field is 8 bits wide in the first case and 11 bits in the second.

An operation enters as one item on a valid/ready input stream. The item carries operand A, operand B, a 2-bit group select and a 3-bit function code. One cycle after it is accepted, the result leaves on a valid/ready output stream through a single register stage. The result has three parts:

- a floating-point word (for compares, the Boolean zero-extended into bit 0);
- the Boolean on its own;
- an invalid-operation flag.

Back-pressure follows a single rule: the input is ready whenever the output register is empty or is being drained in the same cycle. While the output waits for ready, the output item stays frozen.

Top module: `fsmc_unit`

## Requirements
- R1: Group 00 (sign-inject) with function 000 returns A's magnitude bits (all but the top bit) with B's sign bit.
- R2: Group 00 with function 001 returns A's magnitude bits with the inverse of B's sign bit.
- R3: Group 00 with function 010 returns A's magnitude bits with the XOR of the sign bits of A and B.
- R4: The sign-inject group never raises invalid and passes NaN payload bits through unchanged.
- R5: Group 01 (min/max) with function 000 returns the smaller operand and with function 001 returns the larger one. Ordering is by sign and magnitude, and -0 counts as smaller than +0.
- R6: In min/max, when exactly one operand is NaN the other operand is returned. When both are NaN the canonical quiet NaN is returned: sign 0, exponent all ones, top mantissa bit 1, rest 0 (0x7FC00000 for 32 bits).
- R7: Min/max raises invalid when either operand is a signaling NaN: exponent all ones, mantissa nonzero, top mantissa bit 0. A quiet NaN alone does not raise it.
- R8: Group 10 (compare) with function 010 tests equal, 001 tests less-than and 000 tests less-or-equal. The Boolean appears on `out_bool` and in bit 0 of `out_value`, with all other bits zero. +0 and -0 compare equal.
- R9: Every compare returns 0 when either operand is NaN.
- R10: Compares raise invalid only when an operand is a signaling NaN.
- R11: Group 11, or a function code not listed for its group, yields a zero word, a zero Boolean and no invalid.
- R12: An item is accepted when `in_valid` and `in_ready` are both 1, where `in_ready` is `!out_valid || out_ready`. Its result is presented the next cycle. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R13: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an item |
| in_a | input | FLEN | Operand A |
| in_b | input | FLEN | Operand B |
| in_grp | input | 2 | Group: 00 sign-inject, 01 min/max, 10 compare |
| in_fn | input | 3 | Function code within the group |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | FLEN | Result word |
| out_bool | output | 1 | Compare outcome |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
Fifteen operand encodings are applied pairwise under every group and every function code. They are:

- both zeros and both unit values;
- a mixed-sign pair with different magnitudes;
- both infinities, two subnormals and the largest normal;
- two quiet NaNs and two signaling NaNs.

Crossing signed values with unequal magnitudes separates sign-magnitude ordering from plain unsigned ordering. The ±0 pairs separate compare equality from the min/max tie-break. The NaN kinds show whether quiet and signaling inputs are told apart in both the result and the invalid flag. Randomised output stalls exercise the hold and acceptance rules.

// File: rtl/fsmc_pkg.sv
package fsmc_pkg;
  typedef enum logic [1:0] {
    GRP_SGN = 2'b00,
    GRP_MM  = 2'b01,
    GRP_CMP = 2'b10,
    GRP_RSV = 2'b11
  } fsmc_grp_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fsmc_cls_t;

  function automatic int unsigned exp_width(int unsigned flen);
    return (flen == 64) ? 11 : 8;
  endfunction
endpackage

// File: rtl/fsmc_classify.sv
module fsmc_classify
  import fsmc_pkg::*;
#(
  parameter int unsigned FLEN  = 32,
  parameter int unsigned EXP_W = 8
) (
  input  logic [FLEN-2:0] mag,
  output fsmc_cls_t       cls
);
  localparam int unsigned MAN_W = FLEN - 1 - EXP_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;

  always_comb begin
    expo        = mag[FLEN-2 -: EXP_W];
    mant        = mag[MAN_W-1:0];
    cls.is_nan  = (&expo) && (|mant);
    cls.is_snan = (&expo) && (|mant) && !mant[MAN_W-1];
    cls.is_zero = ~|mag;
  end
endmodule

// File: rtl/fsmc_order.sv
module fsmc_order #(
  parameter int unsigned FLEN = 32
) (
  input  logic [FLEN-1:0] a,
  input  logic [FLEN-1:0] b,
  input  logic            a_zero,
  input  logic            b_zero,
  output logic            lt,
  output logic            eq,
  output logic            lt_tot
);
  logic sa, sb, mag_lt, mag_eq, both_zero;

  always_comb begin
    sa        = a[FLEN-1];
    sb        = b[FLEN-1];
    mag_lt    = a[FLEN-2:0] < b[FLEN-2:0];
    mag_eq    = a[FLEN-2:0] == b[FLEN-2:0];
    both_zero = a_zero && b_zero;
    eq        = both_zero || (a == b);
    if (both_zero)      lt = 1'b0;
    else if (sa != sb)  lt = sa;
    else if (!sa)       lt = mag_lt;
    else                lt = !mag_lt && !mag_eq;
    // total order for min/max: -0 ranks below +0
    lt_tot = lt || (both_zero && sa && !sb);
  end
endmodule

// File: rtl/fsmc_compute.sv
module fsmc_compute
  import fsmc_pkg::*;
#(
  parameter int unsigned FLEN  = 32,
  parameter int unsigned EXP_W = 8
) (
  input  logic [FLEN-1:0] a,
  input  logic [FLEN-1:0] b,
  input  logic [1:0]      grp,
  input  logic [2:0]      fn,
  input  logic            a_nan,
  input  logic            b_nan,
  input  logic            a_snan,
  input  logic            b_snan,
  input  logic            lt,
  input  logic            eq,
  input  logic            lt_tot,
  output logic [FLEN-1:0] res_val,
  output logic            res_bool,
  output logic            res_inv
);
  localparam int unsigned MAN_W = FLEN - 1 - EXP_W;
  localparam logic [FLEN-1:0] CANON_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic any_nan, any_snan, pick_a_min;

  always_comb begin
    any_nan    = a_nan || b_nan;
    any_snan   = a_snan || b_snan;
    pick_a_min = lt_tot;
    res_val    = '0;
    res_bool   = 1'b0;
    res_inv    = 1'b0;
    unique case (grp)
      GRP_SGN: begin
        unique case (fn)
          3'd0:    res_val = {b[FLEN-1], a[FLEN-2:0]};
          3'd1:    res_val = {~b[FLEN-1], a[FLEN-2:0]};
          3'd2:    res_val = {a[FLEN-1] ^ b[FLEN-1], a[FLEN-2:0]};
          default: res_val = '0;
        endcase
      end
      GRP_MM: begin
        if (fn <= 3'd1) begin
          res_inv = any_snan;
          if (a_nan && b_nan)  res_val = CANON_QNAN;
          else if (a_nan)      res_val = b;
          else if (b_nan)      res_val = a;
          else if (fn == 3'd0) res_val = pick_a_min ? a : b;
          else                 res_val = pick_a_min ? b : a;
        end
      end
      GRP_CMP: begin
        if (fn <= 3'd2) begin
          res_inv = any_snan;
          unique case (fn)
            3'd2:    res_bool = !any_nan && eq;
            3'd1:    res_bool = !any_nan && lt;
            default: res_bool = !any_nan && (lt || eq);
          endcase
          res_val = {{(FLEN-1){1'b0}}, res_bool};
        end
      end
      default: begin
        res_val = '0;
      end
    endcase
  end
endmodule

// File: rtl/fsmc_unit.sv
module fsmc_unit
  import fsmc_pkg::*;
#(
  parameter int unsigned FLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FLEN-1:0] in_a,
  input  logic [FLEN-1:0] in_b,
  input  logic [1:0]      in_grp,
  input  logic [2:0]      in_fn,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [FLEN-1:0] out_value,
  output logic            out_bool,
  output logic            out_invalid
);
  localparam int unsigned EXP_W = exp_width(FLEN);
  localparam int unsigned NOPS  = 2;

  logic [FLEN-1:0] ops [NOPS];
  fsmc_cls_t       cls [NOPS];

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fsmc_classify #(.FLEN(FLEN), .EXP_W(EXP_W)) u_cls (
      .mag (ops[gi][FLEN-2:0]),
      .cls (cls[gi])
    );
  end

  logic lt, eq, lt_tot;
  fsmc_order #(.FLEN(FLEN)) u_ord (
    .a      (in_a),
    .b      (in_b),
    .a_zero (cls[0].is_zero),
    .b_zero (cls[1].is_zero),
    .lt     (lt),
    .eq     (eq),
    .lt_tot (lt_tot)
  );

  logic [FLEN-1:0] res_val;
  logic            res_bool, res_inv;
  fsmc_compute #(.FLEN(FLEN), .EXP_W(EXP_W)) u_cmp (
    .a        (in_a),
    .b        (in_b),
    .grp      (in_grp),
    .fn       (in_fn),
    .a_nan    (cls[0].is_nan),
    .b_nan    (cls[1].is_nan),
    .a_snan   (cls[0].is_snan),
    .b_snan   (cls[1].is_snan),
    .lt       (lt),
    .eq       (eq),
    .lt_tot   (lt_tot),
    .res_val  (res_val),
    .res_bool (res_bool),
    .res_inv  (res_inv)
  );

  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_value   <= '0;
      out_bool    <= 1'b0;
      out_invalid <= 1'b0;
    end else if (fire) begin
      out_valid   <= 1'b1;
      out_value   <= res_val;
      out_bool    <= res_bool;
      out_invalid <= res_inv;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_bool) && $stable(out_invalid)); // R12
  AST_SGN_MAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_grp == GRP_SGN && in_fn <= 3'd2 |=> out_value[FLEN-2:0] == $past(in_a[FLEN-2:0])); // R1
  AST_SGN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_grp == GRP_SGN |=> !out_invalid); // R4
  AST_CMP_NAN_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_grp == GRP_CMP && (cls[0].is_nan || cls[1].is_nan) |=> !out_bool && out_value == '0); // R9
  AST_MM_QUIET_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_grp == GRP_MM && !cls[0].is_snan && !cls[1].is_snan |=> !out_invalid); // R7
endmodule

// File: tb/tb_fsmc_unit.sv
`timescale 1ns/1ps
module tb_fsmc_unit;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] v;
    logic         b;
    logic         inv;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, stall_en = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic [1:0] in_grp = '0;
  logic [2:0] in_fn = '0;
  logic in_ready, out_valid, out_bool, out_invalid;
  logic [W-1:0] out_value;

  int checks = 0, fails = 0, cyc = 0;
  exp_t  expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  fsmc_unit #(.FLEN(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_grp(in_grp), .in_fn(in_fn),
    .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value),
    .out_bool(out_bool), .out_invalid(out_invalid)
  );

  function automatic logic f_nan(logic [W-1:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic logic f_snan(logic [W-1:0] x);
    return f_nan(x) && !x[22];
  endfunction
  function automatic logic signed [32:0] f_key(logic [W-1:0] x);
    logic signed [32:0] m;
    m = $signed({2'b00, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  function automatic exp_t ref_model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] g, logic [2:0] f);
    exp_t e;
    logic signed [32:0] ka, kb;
    logic an, bn, sn, zz;
    e = '0;
    ka = f_key(a); kb = f_key(b);
    an = f_nan(a); bn = f_nan(b); sn = f_snan(a) || f_snan(b);
    zz = (a[30:0] == 0) && (b[30:0] == 0);
    if (g == 2'd0) begin
      if (f == 3'd0) e.v = {b[31], a[30:0]};
      else if (f == 3'd1) e.v = {!b[31], a[30:0]};
      else if (f == 3'd2) e.v = {a[31] != b[31], a[30:0]};
    end else if (g == 2'd1 && f <= 3'd1) begin
      e.inv = sn;
      if (an && bn) e.v = 32'h7FC0_0000;
      else if (an) e.v = b;
      else if (bn) e.v = a;
      else if (zz) e.v = (f == 3'd0) ? (a[31] ? a : b) : (a[31] ? b : a);
      else if (ka < kb) e.v = (f == 3'd0) ? a : b;
      else if (kb < ka) e.v = (f == 3'd0) ? b : a;
      else e.v = a;
    end else if (g == 2'd2 && f <= 3'd2) begin
      e.inv = sn;
      if (!(an || bn)) begin
        if (f == 3'd2) e.b = (ka == kb);
        else if (f == 3'd1) e.b = (ka < kb);
        else e.b = (ka <= kb);
      end
      e.v = {31'd0, e.b};
    end
    return e;
  endfunction

  function automatic string req_tag(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] g, logic [2:0] f);
    logic an, sn;
    an = f_nan(a) || f_nan(b); sn = f_snan(a) || f_snan(b);
    if (g == 2'd0) begin
      if (f > 3'd2) return "R11";
      if (an) return "R4";
      return (f == 3'd0) ? "R1" : (f == 3'd1) ? "R2" : "R3";
    end else if (g == 2'd1) begin
      if (f > 3'd1) return "R11";
      return sn ? "R7" : an ? "R6" : "R5";
    end else if (g == 2'd2) begin
      if (f > 3'd2) return "R11";
      return sn ? "R10" : an ? "R9" : "R8";
    end
    return "R11";
  endfunction

  task automatic check(string tag, logic ok, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] g, logic [2:0] f);
    @(negedge clk);
    in_a = a; in_b = b; in_grp = g; in_fn = f; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    expq.push_back(ref_model(a, b, g, f));
    tagq.push_back(req_tag(a, b, g, f));
  endtask

  // ready pattern changes shortly after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    out_ready = !stall_en || ((cyc % 3) != 0);
  end

  // scoreboard monitor
  logic         held_pend = 1'b0;
  logic [W-1:0] held_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pend) begin
        check("R12", out_valid && out_value == held_val, {63'd0, out_valid} << 32 | out_value, {32'd1, held_val});
      end
      held_pend = out_valid && !out_ready;
      held_val  = out_value;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R12", 1'b0, 64'd1, 64'd0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, out_value == e.v && out_bool == e.b && out_invalid == e.inv,
                {30'd0, out_bool, out_invalid, out_value}, {30'd0, e.b, e.inv, e.v});
        end
      end
    end
  end

  localparam logic [W-1:0] VALS [15] = '{
    32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000,
    32'hC020_0000, 32'h7F80_0000, 32'hFF80_0000, 32'h0000_0001, 32'h8040_0000,
    32'h7FC0_0001, 32'hFFC1_2345, 32'h7F80_0001, 32'hFFA0_0000, 32'h7F7F_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    check("R13", out_valid == 1'b0 && in_ready == 1'b1, {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    // directed boundary items: R8 zero equality, R6 canonical NaN, R1 sign copy
    send(32'h0000_0000, 32'h8000_0000, 2'd2, 3'd2);
    send(32'h7FC0_0001, 32'hFFC1_2345, 2'd1, 3'd0);
    send(32'h3F80_0000, 32'h8000_0000, 2'd0, 3'd0);
    for (int ph = 0; ph < 2; ph++) begin
      stall_en = (ph == 1);
      for (int g = 0; g < 4; g++)
        for (int f = 0; f < 8; f++)
          for (int i = 0; i < 15; i++)
            for (int j = 0; j < 15; j++)
              send(VALS[i], VALS[j], g[1:0], f[2:0]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 100 && expq.size() != 0; k++) @(negedge clk);
    check("R12", expq.size() == 0, expq.size(), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_800_000;
    fails++;
    checks++;
    $display("FAIL R12 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule